// File: doc/BRIEF.md
# Reference-windowed clock frequency counter

This block estimates the rate of a clock under test. It counts that clock's rising edges during a gate window. The window lasts a programmed number of reference ticks, and the reference tick is the crystal clock divided by four. The host writes a control word that holds the window length and a start bit. It then reads a status word that holds a single flag and the captured edge count. The counter logic clocked by the measured clock is cleared only by that clock. A stopped clock under test therefore returns the previous count again instead of zero. Software detects a dead clock by running two measurements and comparing their results.

A measurement goes as follows. The host writes the window length with the start bit clear, which stops and reloads the block. It waits until the flag reads 0. It then writes the length again with the start bit set. When the flag reads 1 again, the count is final. Control and status are plain register pins. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `refwin_freq_counter`

## Requirements
- R1: After reset the status word reads all zeros: the flag (bit 25) is 0 and the count (bits 24:0) is 0.
- R2: A control write with bit 20 clear loads bits 19:0 and stops any run. It holds the status flag at 1 for exactly SETTLE_CYC (16) clocks, counted from the write edge, and the flag then reads 0.
- R3: A control write with bit 20 set, made while the block is ready, opens a window of 4×N clocks, where N is bits 19:0 of that write. The flag reads 0 throughout the window.
- R4: Within DRAIN_CYC (64) clocks after the window closes, the flag goes to 1. It stays at 1 until the next write with bit 20 clear.
- R5: The count field gives the number of rising edges of the measured clock during the window, within ±2.
- R6: If the measured clock is stopped, a new stop/start run still completes. It reports the same count as the previous run. Once the clock runs again, a new run reports a fresh count.
- R7: The measured-edge counter saturates at all ones of the count width. It never wraps.
- R8: While the reference branch enable is low, no reference ticks advance and a started run does not complete. The flag stays 0. When the enable rises, the run finishes.
- R9: A write with bit 20 set is ignored while the flag reads 1, either during settling or after completion. The flag, the count and the window timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock; also clocks the register interface |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| ref_branch_en | input | 1 | Enables the divide-by-four reference tick |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: bits 19:0 window length in ticks, bit 20 start |
| status | output | 32 | Bit 25 busy/done flag, bits 24:0 captured count, others 0 |
| meas_clk | input | 1 | Clock under test |

## Verification
The bench drives the clock under test at several periods that are not related to the reference. It checks the count against the window length in nanoseconds divided by the period, within ±2. A sync path that dropped or added a cycle at either edge of the window would fall outside that band. The flag is compared on every clock of the settle and window phases, so a settle timer or tick divider that is one cycle off shows up at once. The bench also stops the clock under test and expects the old count back; a design that zeroed the counter from the register domain would return 0 instead. It runs a narrow-count instance in saturation, where a wrapping counter would return a small residue. Finally it issues starts while the flag is 1, and a design that honoured them would drop the flag or alter the count.

// File: rtl/refwin_pkg.sv
package refwin_pkg;
  typedef enum logic [2:0] {
    ST_READY,
    ST_SETTLE,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } win_state_t;
endpackage

// File: rtl/refwin_sync.sv
module refwin_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/refwin_refdiv.sv
module refwin_refdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] phase;

  assign tick = en && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (clr) begin
      phase <= '0;
    end else if (en) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/refwin_meas.sv
module refwin_meas #(
  parameter int CNT_W = 25
) (
  input  logic             meas_clk,
  input  logic             rst_n,
  input  logic             run_lvl,
  input  logic             clr_tgl,
  output logic             snap_tgl,
  output logic [CNT_W-1:0] snap_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0]       sync_q;
  logic             run_s, clr_s, run_d, clr_d;
  logic             clr_pulse, run_fall;
  logic [CNT_W-1:0] edge_cnt;

  refwin_sync #(.W(2)) u_sync (
    .clk   (meas_clk),
    .rst_n (rst_n),
    .d     ({run_lvl, clr_tgl}),
    .q     (sync_q)
  );

  assign run_s     = sync_q[1];
  assign clr_s     = sync_q[0];
  assign clr_pulse = clr_s ^ clr_d;
  assign run_fall  = run_d & ~run_s;

  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d    <= 1'b0;
      clr_d    <= 1'b0;
      edge_cnt <= '0;
      snap_cnt <= '0;
      snap_tgl <= 1'b0;
    end else begin
      run_d <= run_s;
      clr_d <= clr_s;
      if (clr_pulse) begin
        edge_cnt <= '0;
      end else if (run_s && (edge_cnt != CNT_MAX)) begin
        edge_cnt <= edge_cnt + 1'b1;
      end
      if (run_fall) begin
        snap_cnt <= edge_cnt;
        snap_tgl <= ~snap_tgl;
      end
    end
  end

  // R7: the counter only moves upward between clears
  a_r7_no_wrap: assert property (@(posedge meas_clk) disable iff (!rst_n)
    !clr_pulse |=> (edge_cnt >= $past(edge_cnt)));

  // R5: the published snapshot holds still except at a window close
  a_r5_snap_hold: assert property (@(posedge meas_clk) disable iff (!rst_n)
    !run_fall |=> $stable(snap_cnt));
endmodule

// File: rtl/refwin_ctrl.sv
module refwin_ctrl
  import refwin_pkg::*;
#(
  parameter int TICK_W     = 20,
  parameter int CNT_W      = 25,
  parameter int SETTLE_CYC = 16,
  parameter int DRAIN_CYC  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_start,
  input  logic [TICK_W-1:0] win_ticks,
  input  logic              tick,
  input  logic              snap_tgl_s,
  input  logic [CNT_W-1:0]  snap_cnt,
  output logic              div_clr,
  output logic              run_lvl,
  output logic              clr_tgl,
  output logic [31:0]       status
);
  localparam int TMAX = (SETTLE_CYC > DRAIN_CYC) ? SETTLE_CYC : DRAIN_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PAD  = 31 - CNT_W;

  win_state_t        state;
  logic [TICK_W-1:0] tick_cnt;
  logic [TW-1:0]     timer;
  logic [CNT_W-1:0]  cap;
  logic              snap_d, snap_edge, flag, stop_wr;

  assign snap_edge = snap_tgl_s ^ snap_d;
  assign stop_wr   = ctl_we && !ctl_start;
  assign div_clr   = ctl_we;
  assign flag      = (state == ST_SETTLE) || (state == ST_DONE);
  assign status    = {{PAD{1'b0}}, flag, cap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_READY;
      tick_cnt <= '0;
      timer    <= '0;
      run_lvl  <= 1'b0;
      clr_tgl  <= 1'b0;
      cap      <= '0;
      snap_d   <= 1'b0;
    end else begin
      snap_d <= snap_tgl_s;
      if (snap_edge) cap <= snap_cnt;
      if (stop_wr) begin
        state    <= ST_SETTLE;
        tick_cnt <= win_ticks;
        timer    <= TW'(SETTLE_CYC - 1);
        run_lvl  <= 1'b0;
        clr_tgl  <= ~clr_tgl;
      end else begin
        unique case (state)
          ST_SETTLE: begin
            if (timer == '0) state <= ST_READY;
            else timer <= timer - 1'b1;
          end
          ST_READY: begin
            if (ctl_we && ctl_start) begin
              tick_cnt <= win_ticks;
              if (win_ticks == '0) begin
                state <= ST_DRAIN;
                timer <= TW'(DRAIN_CYC - 1);
              end else begin
                state   <= ST_RUN;
                run_lvl <= 1'b1;
              end
            end
          end
          ST_RUN: begin
            if (tick) begin
              if (tick_cnt == TICK_W'(1)) begin
                tick_cnt <= '0;
                run_lvl  <= 1'b0;
                state    <= ST_DRAIN;
                timer    <= TW'(DRAIN_CYC - 1);
              end else begin
                tick_cnt <= tick_cnt - 1'b1;
              end
            end
          end
          ST_DRAIN: begin
            if (snap_edge || (timer == '0)) state <= ST_DONE;
            else timer <= timer - 1'b1;
          end
          ST_DONE: ;
          default: state <= ST_READY;
        endcase
      end
    end
  end

  // R2: a stop write always lands in settling with the gate closed
  a_r2_stop_settles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (state == ST_SETTLE) && !run_lvl);

  // R8: without a reference tick the window neither advances nor ends
  a_r8_tick_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !tick && !ctl_we) |=> (state == ST_RUN) && $stable(tick_cnt));

  // R4, R9: completion is sticky until a stop write
  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !stop_wr) |=> (state == ST_DONE));

  // R5: the captured count changes only when a snapshot arrives
  a_r5_cap_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_edge |=> $stable(cap));
endmodule

// File: rtl/refwin_freq_counter.sv
module refwin_freq_counter #(
  parameter int TICK_W     = 20,
  parameter int CNT_W      = 25,
  parameter int REF_DIV    = 4,
  parameter int SETTLE_CYC = 16,
  parameter int DRAIN_CYC  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_branch_en,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] status,
  input  logic        meas_clk
);
  localparam int START_BIT = TICK_W;

  logic             tick, div_clr, run_lvl, clr_tgl;
  logic             snap_tgl, snap_tgl_s;
  logic [CNT_W-1:0] snap_cnt;
  logic             unused_hi_bits;

  assign unused_hi_bits = ^ctl_wdata[31:START_BIT+1];

  refwin_refdiv #(.DIV(REF_DIV)) u_refdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ref_branch_en),
    .clr   (div_clr),
    .tick  (tick)
  );

  refwin_ctrl #(
    .TICK_W     (TICK_W),
    .CNT_W      (CNT_W),
    .SETTLE_CYC (SETTLE_CYC),
    .DRAIN_CYC  (DRAIN_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_start  (ctl_wdata[START_BIT]),
    .win_ticks  (ctl_wdata[TICK_W-1:0]),
    .tick       (tick),
    .snap_tgl_s (snap_tgl_s),
    .snap_cnt   (snap_cnt),
    .div_clr    (div_clr),
    .run_lvl    (run_lvl),
    .clr_tgl    (clr_tgl),
    .status     (status)
  );

  refwin_meas #(.CNT_W(CNT_W)) u_meas (
    .meas_clk (meas_clk),
    .rst_n    (rst_n),
    .run_lvl  (run_lvl),
    .clr_tgl  (clr_tgl),
    .snap_tgl (snap_tgl),
    .snap_cnt (snap_cnt)
  );

  refwin_sync #(.W(1)) u_snap_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (snap_tgl),
    .q     (snap_tgl_s)
  );
endmodule

// File: tb/refwin_freq_counter_bench.sv
`timescale 1ns/1ps
module refwin_freq_counter_bench;
  localparam int SETTLE = 16;
  localparam int DRAIN  = 64;
  localparam logic [31:0] START = 32'h0010_0000;

  logic clk = 1'b0, rst_n = 1'b0, ref_en = 1'b1, ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] status, sat_status;
  logic meas_clk = 1'b0;
  bit   meas_on = 1'b1;
  real  meas_half = 4.15;
  int   total = 0, bad = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  always begin
    if (meas_on) begin
      #(meas_half) meas_clk = ~meas_clk;
    end else begin
      #1;
    end
  end

  refwin_freq_counter u_refwin_freq_counter (
    .clk(clk), .rst_n(rst_n), .ref_branch_en(ref_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .status(status), .meas_clk(meas_clk)
  );

  refwin_freq_counter #(.CNT_W(6)) u_refwin_freq_counter_sat (
    .clk(clk), .rst_n(rst_n), .ref_branch_en(ref_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .status(sat_status), .meas_clk(meas_clk)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    ctl_we = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
    ctl_wdata = '0;
  endtask

  // flag model: 1 for exactly SETTLE clocks from the write edge, then 0
  task automatic do_stop(input int n, input bit intrude);
    wr(32'(n));
    for (int k = 0; k <= SETTLE; k++) begin
      chk(status[25] == (k < SETTLE), intrude ? "R2/R9 settle flag" : "R2 settle flag",
          status[25], (k < SETTLE));
      if (intrude && k == 0) begin
        ctl_we = 1'b1;
        ctl_wdata = START | 32'd16;
      end
      @(negedge clk);
      ctl_we = 1'b0;
      ctl_wdata = '0;
    end
  endtask

  // flag model: 0 for the 4*n window clocks and the closing edge, then 1
  task automatic do_start(input int n, output int cnt);
    int w;
    wr(START | 32'(n));
    for (int k = 0; k <= 4 * n; k++) begin
      chk(status[25] == 1'b0, "R3 window flag", status[25], 0);
      @(negedge clk);
    end
    w = 0;
    while (!status[25] && w < DRAIN + 8) begin
      @(negedge clk);
      w++;
    end
    chk(status[25] == 1'b1, "R4 done flag", status[25], 1);
    cnt = int'(status[24:0]);
  endtask

  task automatic chk_cnt(input int cnt, input real period, input int n, input string tag);
    real expv;
    expv = 16.0 * n / period;
    chk((real'(cnt) > expv - 2.5) && (real'(cnt) < expv + 2.5), tag, cnt, longint'(expv));
  endtask

  task automatic set_period(input real p);
    meas_half = p / 2.0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    int c, last;
    repeat (5) @(negedge clk);
    chk(status == 32'd0, "R1 reset status", status, 0);
    chk(sat_status == 32'd0, "R1 reset status narrow", sat_status, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    set_period(8.3);
    do_stop(16, 1'b0);
    do_start(16, c);
    chk_cnt(c, 8.3, 16, "R5 count 8.3ns");

    set_period(2.1);
    do_stop(16, 1'b0);
    do_start(16, c);
    chk_cnt(c, 2.1, 16, "R5 count 2.1ns");
    chk(sat_status[5:0] == 6'h3f, "R7 saturation", sat_status[5:0], 63);
    chk(sat_status[6] == 1'b1, "R7 narrow done flag", sat_status[6], 1);

    set_period(6.2);
    do_stop(24, 1'b0);
    do_start(24, c);
    chk_cnt(c, 6.2, 24, "R5 count 6.2ns");

    set_period(10.3);
    do_stop(50, 1'b0);
    do_start(50, c);
    chk_cnt(c, 10.3, 50, "R5 count 10.3ns");

    set_period(4.4);
    do_stop(64, 1'b0);
    do_start(64, c);
    chk_cnt(c, 4.4, 64, "R5 count 4.4ns");

    // start while done: ignored
    wr(START | 32'd16);
    for (int k = 0; k < 4 * 16 + DRAIN + 16; k++) begin
      chk(status[25] == 1'b1, "R9 start in done flag", status[25], 1);
      @(negedge clk);
    end
    chk(int'(status[24:0]) == c, "R9 start in done count", status[24:0], c);

    // start during settling: ignored, no run follows
    do_stop(16, 1'b1);
    for (int k = 0; k < 4 * 16 + DRAIN + 16; k++) begin
      chk(status[25] == 1'b0, "R9 no run after settle start", status[25], 0);
      @(negedge clk);
    end
    chk(int'(status[24:0]) == c, "R9 settle start count", status[24:0], c);

    // branch enable low: run cannot finish
    ref_en = 1'b0;
    do_stop(4, 1'b0);
    wr(START | 32'd4);
    for (int k = 0; k < 200; k++) begin
      chk(status[25] == 1'b0, "R8 stalled flag", status[25], 0);
      @(negedge clk);
    end
    ref_en = 1'b1;
    begin
      int w;
      w = 0;
      while (!status[25] && w < 16 + DRAIN + 16) begin
        @(negedge clk);
        w++;
      end
    end
    chk(status[25] == 1'b1, "R8 resumes and completes", status[25], 1);
    last = int'(status[24:0]);

    // stopped measured clock: stale count repeats
    meas_on = 1'b0;
    repeat (10) @(negedge clk);
    do_stop(16, 1'b0);
    do_start(16, c);
    chk(c == last, "R6 stale count", c, last);

    meas_on = 1'b1;
    set_period(8.3);
    do_stop(16, 1'b0);
    do_start(16, c);
    chk_cnt(c, 8.3, 16, "R6 fresh count after restart");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule